// File: doc/BRIEF.md
# DAC Core Word Load Controller

This block decides when a value written to the DAC data register reaches the converter core. It keeps a 12-bit data register that a processor loads through a one-cycle write strobe, and a 12-bit core latch that drives the converter. A 2-bit load-select input sets how the latch is refreshed. In one mode the latch is transparent. In another it is loaded after each register write. In the remaining two it is loaded on the rising edge of one of two timer compare signals.

A convert-enable input gates every buffered mode, and the transparent mode ignores it. Rising edges on the timer signals are found by comparing each input with a copy registered one cycle earlier. A synchronous, active-high reset clears the data register, the core latch, the pending-write flag and the edge history.

Top module: `dac_load_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the data register, core latch and edge history are cleared, so `core_word` reads 0 after that edge.
- R2: With `load_sel` = 0, `core_word` takes a written value at the same edge that captures the write, whatever the state of `conv_en`. Without a write, `core_word` equals the data register one edge after the mode is selected.
- R3: With `load_sel` = 1 and `conv_en` high, the latch loads the data register at the edge after the one that captured the write. `core_word` keeps its old value for one cycle and then shows the new value.
- R4: With `load_sel` = 2 and `conv_en` high, the first edge at which `trig_a` is sampled high after being sampled low loads the data register into the latch.
- R5: With `load_sel` = 3 and `conv_en` high, a rising edge on `trig_b`, found the same way, loads the data register into the latch.
- R6: With `load_sel` set to 1, 2 or 3 and `conv_en` low, `core_word` holds its value through writes and trigger edges.
- R7: Only a low-to-high transition of the trigger selected by the mode loads the latch. A trigger held high does not load, and the trigger of the other mode does not load either.
- R8: In modes 2 and 3, when a trigger edge and a write fall in the same cycle, the latch takes the data register value from before that write. The new value is applied at the next trigger edge.
- R9: In modes 2 and 3, a register write on its own does not change `core_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe for the data register |
| wr_data | input | 12 | Value to write into the data register |
| load_sel | input | 2 | Load mode: 0 transparent, 1 after write, 2 on `trig_a` rise, 3 on `trig_b` rise |
| conv_en | input | 1 | Convert enable that gates modes 1 to 3 |
| trig_a | input | 1 | First timer compare signal |
| trig_b | input | 1 | Second timer compare signal |
| core_word | output | 12 | Word presented to the converter core |

## Verification
The trigger assertions assume that both timer inputs are already synchronous to `clk` and are held low during reset. They detect an edge by comparing a trigger with its own previous sample, and this matches the design's cleared edge history only under that assumption. The stimulus changes every input at a point away from the active edge and keeps `trig_a` and `trig_b` low whenever `rst` is asserted. `load_sel` is changed only in cycles where no trigger edge or pending write loses its meaning.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;

    typedef enum logic [1:0] {
        LS_DIRECT   = 2'd0,
        LS_ON_WRITE = 2'd1,
        LS_TRIG_A   = 2'd2,
        LS_TRIG_B   = 2'd3
    } load_mode_e;

endpackage

// File: rtl/dac_rise_det.sv
module dac_rise_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trig_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = trig_in;
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = trig_in[i] & ~hist_q[i];
    end
endmodule

// File: rtl/dac_load_gate.sv
module dac_load_gate
    import dac_load_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       conv_en,
    input  logic       wr_seen,
    input  logic [1:0] rise,
    output logic       pass_thru,
    output logic       do_load
);
    load_mode_e mode_e;

    always_comb begin
        mode_e    = load_mode_e'(mode);
        pass_thru = (mode_e == LS_DIRECT);
        unique case (mode_e)
            LS_ON_WRITE: do_load = conv_en & wr_seen;
            LS_TRIG_A:   do_load = conv_en & rise[0];
            LS_TRIG_B:   do_load = conv_en & rise[1];
            default:     do_load = 1'b0;
        endcase
    end
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        load_sel,
    input  logic              conv_en,
    input  logic              trig_a,
    input  logic              trig_b,
    output logic [DATA_W-1:0] core_word
);
    localparam int N_TRIG = 2;

    typedef struct packed {
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] core;
        logic              wr_seen;
    } st_t;

    st_t st_d, st_q;
    logic [N_TRIG-1:0] trig_vec, trig_rise;
    logic pass_thru, do_load;

    assign trig_vec = {trig_b, trig_a};

    dac_rise_det #(.N(N_TRIG)) u_rise (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_vec),
        .rise    (trig_rise)
    );

    dac_load_gate u_gate (
        .mode      (load_sel),
        .conv_en   (conv_en),
        .wr_seen   (st_q.wr_seen),
        .rise      (trig_rise),
        .pass_thru (pass_thru),
        .do_load   (do_load)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wr_seen = wr_en;
        if (wr_en) st_d.dat = wr_data;
        if (pass_thru)    st_d.core = st_d.dat;   // transparent path
        else if (do_load) st_d.core = st_q.dat;   // value held before this cycle's write
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign core_word = st_q.core;
endmodule

// File: rtl/dac_load_chk.sv
module dac_load_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        load_sel,
    input logic              conv_en,
    input logic              trig_a,
    input logic              trig_b,
    input logic [DATA_W-1:0] core_word,
    input logic [DATA_W-1:0] dat_q
);
    a_r2_transparent: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'd0 && wr_en) |=> core_word == $past(wr_data));

    a_r3_write_load: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'd1 && conv_en && $past(wr_en) && !$past(rst))
        |=> core_word == $past(dat_q));

    a_r4_trig_a_load: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'd2 && conv_en && trig_a && !$past(trig_a) && !$past(rst))
        |=> core_word == $past(dat_q));

    a_r5_trig_b_load: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'd3 && conv_en && trig_b && !$past(trig_b) && !$past(rst))
        |=> core_word == $past(dat_q));

    a_r6_gated_hold: assert property (@(posedge clk) disable iff (rst)
        (load_sel != 2'd0 && !conv_en) |=> $stable(core_word));

    a_r7_no_edge_a: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'd2 && !$past(rst) && !(trig_a && !$past(trig_a)))
        |=> $stable(core_word));

    a_r7_no_edge_b: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'd3 && !$past(rst) && !(trig_b && !$past(trig_b)))
        |=> $stable(core_word));
endmodule

bind dac_load_ctrl dac_load_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .load_sel  (load_sel),
    .conv_en   (conv_en),
    .trig_a    (trig_a),
    .trig_b    (trig_b),
    .core_word (core_word),
    .dat_q     (st_q.dat)
);

// File: tb/sim_dac_load_ctrl.sv
module sim_dac_load_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [1:0]  load_sel = 2'd0;
    logic        conv_en = 1'b0;
    logic        trig_a = 1'b0;
    logic        trig_b = 1'b0;
    logic [11:0] core_word;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    dac_load_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .load_sel(load_sel), .conv_en(conv_en), .trig_a(trig_a),
        .trig_b(trig_b), .core_word(core_word)
    );

    // Monitor: compares the head of the scoreboard at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (core_word !== e.val) begin
                n_err++;
                $display("FAIL %s: core_word actual=%h expected=%h", e.tag, core_word, e.val);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected<=5000", cyc);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [11:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic write(input logic [11:0] v);
        wr_en = 1'b1;
        wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        push(12'h000, "R1 after reset");

        // transparent mode, enable low then high
        write(12'h123);           push(12'h123, "R2 enable low");
        conv_en = 1'b1;
        write(12'hABC);           push(12'hABC, "R2 enable high");

        // load after write
        load_sel = 2'd1;
        write(12'h456);           push(12'hABC, "R3 one cycle delay");
        step();                   push(12'h456, "R3 loaded");
        conv_en = 1'b0;
        write(12'h789); step();   push(12'h456, "R6 mode1 gated");

        // timer A mode
        load_sel = 2'd2; conv_en = 1'b1;
        write(12'h111); step();   push(12'h456, "R9 write alone mode2");
        trig_b = 1'b1; step();    push(12'h456, "R7 other trigger");
        trig_b = 1'b0; step();
        trig_a = 1'b1; step();    push(12'h111, "R4 trig_a rise");
        write(12'h222); step();   push(12'h111, "R7 held high");
        trig_a = 1'b0; step();
        trig_a = 1'b1; step();    push(12'h222, "R7 new rise");
        trig_a = 1'b0; step();
        trig_a = 1'b1; write(12'h333);
                                  push(12'h222, "R8 same cycle old value");
        trig_a = 1'b0; step();
        trig_a = 1'b1; step();    push(12'h333, "R8 next edge");
        trig_a = 1'b0; step();

        // timer B mode
        load_sel = 2'd3;
        trig_a = 1'b1; write(12'h444);
                                  push(12'h333, "R9 write and trig_a in mode3");
        trig_a = 1'b0;
        trig_b = 1'b1; step();    push(12'h444, "R5 trig_b rise");
        trig_b = 1'b0; step();

        // gated trigger modes
        conv_en = 1'b0;
        write(12'h555);
        trig_b = 1'b1; step();    push(12'h444, "R6 mode3 gated");
        trig_b = 1'b0;
        load_sel = 2'd2;
        trig_a = 1'b1; step();    push(12'h444, "R6 mode2 gated");
        trig_a = 1'b0; step();

        // back to transparent without a write
        load_sel = 2'd0; step();  push(12'h555, "R2 follows register");

        rst = 1'b1; step();
        rst = 1'b0;               push(12'h000, "R1 mid-run reset");
        step();                   push(12'h000, "R1 register cleared");

        done = 1'b1;
        repeat (2) step();
        finish_run();
    end
endmodule